// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block sits behind a timer's compare unit. It takes the single waveform bit from that unit and produces a pair of gate-drive signals, a true output and a complementary output. In complementary operation the two outputs never overlap. Each output falls as soon as the waveform changes, and it rises only after its own programmable delay has run out. The delays are counted on a prescaled dead-time clock that is derived from the timer clock enable.

If complementary operation is not selected, the block works as a one-stage synchronizer. The true output copies the waveform one timer tick later and the complementary output stays low. An inversion control flips both outputs in complementary operation, so that during the dead interval both outputs are high instead of both low. All state advances only on cycles in which the timer clock enable is high.

Top module: `deadtime_gen`

## Requirements
- R1: A 3-bit prescaler counts `tmr_en` cycles from reset and wraps modulo 8. A tmr_en cycle is a dead-time tick when the low `div_sel` bits of that count (taken before the increment) are all ones. The `div_sel` values 0, 1, 2 and 3 therefore give one dead-time tick every 1, 2, 4 and 8 timer ticks.
- R2: `dt_cfg[3:0]` is the delay of the true output and `dt_cfg[7:4]` is the delay of the complementary output. A delay D makes the output rise on the (D+1)-th dead-time tick after the loading tick.
- R3: In complementary operation the uninverted true and complementary levels are never both 1.
- R4: In synchronizer operation, each tmr_en cycle registers `wave_in` to `gate_p` and drives `gate_n` to 0.
- R5: Complementary operation is active only when `pwm_on`=1 and `cmp_mode`=2'b01. Every other combination gives synchronizer operation.
- R6: While complementary operation is registered as active, `inv_en`=1 inverts both outputs. In that case both outputs are high during the dead interval. `inv_en` has no effect in synchronizer operation.
- R7: Reset (active-low `rst_n`) clears both outputs, the delay counter and the prescaler to 0.
- R8: A delay of 0 makes the output rise on the first dead-time tick after the loading tick.
- R9: When a tmr_en cycle in complementary operation sees a waveform change, the high output falls on that same clock edge.
- R10: A waveform change that arrives before the pending delay has expired reloads the counter for the new level. Both outputs stay low until the reloaded count expires.
- R11: On cycles with `tmr_en`=0 no output and no internal state changes.
- R12: The first tmr_en cycle in complementary operation, after synchronizer operation, counts as a waveform edge. It drops both outputs and loads the delay for the present level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Timer clock enable, one cycle per timer tick |
| wave_in | input | 1 | Waveform bit from the compare unit |
| pwm_on | input | 1 | Timer is in a PWM mode |
| cmp_mode | input | 2 | Compare output mode; 2'b01 selects complementary pair |
| inv_en | input | 1 | Invert both outputs in complementary operation |
| div_sel | input | 2 | Dead-time prescaler select (divide by 2^div_sel) |
| dt_cfg | input | 8 | Delays: [7:4] complementary output, [3:0] true output |
| gate_p | output | 1 | True gate-drive output |
| gate_n | output | 1 | Complementary gate-drive output |

## Verification
The bound checker watches several rules on every cycle. It checks the non-overlap of the two uninverted levels, the low complementary output in synchronizer operation, and the one-tick copy of the waveform in that operation. It also checks that a waveform change in complementary operation drops both outputs on the next edge, and that state is frozen while the timer enable is low. The exact cycle on which a delayed output rises depends on the prescaler phase, the programmed field and any retriggering. Only the bench's behavioural model shows these timings, together with the zero-delay, rapid-toggle, inversion and mode-entry scenarios. The bench compares its model with the outputs on every cycle.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   // compare output mode value that selects the complementary pair
   localparam logic [1:0] CMP_PAIR = 2'b01;

   typedef struct packed {
      logic p;
      logic n;
   } gate_pair_t;

   function automatic logic pair_selected(input logic pwm, input logic [1:0] mode);
      return pwm && (mode == CMP_PAIR);
   endfunction
endpackage

// File: rtl/dtg_prescaler.sv
module dtg_prescaler #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_en,
   input  logic [SEL_W-1:0] div_sel,
   output logic             dt_tick
);
   localparam int PSC_W = (1 << SEL_W) - 1;

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("dtg_prescaler: SEL_W must be 1..3");
      end
   endgenerate

   logic [PSC_W-1:0] psc_q;
   logic [PSC_W-1:0] mask;

   assign mask = ~({PSC_W{1'b1}} << div_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      psc_q <= '0;
      else if (tmr_en) psc_q <= psc_q + 1'b1;
   end

   assign dt_tick = tmr_en && ((psc_q & mask) == mask);
endmodule

// File: rtl/dtg_countdown.sv
module dtg_countdown #(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   input  logic             step,
   output logic             fire
);
   generate
      if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
         $error("dtg_countdown: DLY_W must be 1..16");
      end
   endgenerate

   logic [DLY_W-1:0] cnt_q;
   logic             pend_q;
   logic             zero;

   assign zero = (cnt_q == '0);
   assign fire = pend_q && step && zero && !load && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (clear) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= load_val;
         pend_q <= 1'b1;
      end else if (pend_q && step) begin
         if (zero) pend_q <= 1'b0;
         else      cnt_q  <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/deadtime_gen.sv
module deadtime_gen #(
   parameter int SEL_W = 2,
   parameter int DLY_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tmr_en,
   input  logic               wave_in,
   input  logic               pwm_on,
   input  logic [1:0]         cmp_mode,
   input  logic               inv_en,
   input  logic [SEL_W-1:0]   div_sel,
   input  logic [2*DLY_W-1:0] dt_cfg,
   output logic               gate_p,
   output logic               gate_n
);
   import dtg_pkg::*;

   localparam int CFG_W = 2 * DLY_W;

   logic             comp_en;
   logic             comp_q;
   logic             wave_q;
   logic             dt_tick;
   logic             load;
   logic             clear;
   logic             fire;
   logic [DLY_W-1:0] lag_true;
   logic [DLY_W-1:0] lag_cmpl;
   logic [DLY_W-1:0] load_val;
   gate_pair_t       raw_q;
   logic             p_raw;
   logic             n_raw;

   assign lag_true = dt_cfg[DLY_W-1:0];
   assign lag_cmpl = dt_cfg[CFG_W-1:DLY_W];
   assign comp_en  = pair_selected(pwm_on, cmp_mode);
   assign load     = tmr_en && comp_en && ((wave_in != wave_q) || !comp_q);
   assign clear    = tmr_en && !comp_en;
   assign load_val = wave_in ? lag_true : lag_cmpl;

   dtg_prescaler #(.SEL_W(SEL_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tmr_en  (tmr_en),
      .div_sel (div_sel),
      .dt_tick (dt_tick)
   );

   dtg_countdown #(.DLY_W(DLY_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .load     (load),
      .load_val (load_val),
      .step     (dt_tick),
      .fire     (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
         comp_q <= 1'b0;
      end else if (tmr_en) begin
         wave_q <= wave_in;
         comp_q <= comp_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
      end else if (tmr_en) begin
         if (!comp_en) begin
            raw_q.p <= wave_in;
            raw_q.n <= 1'b0;
         end else if (load) begin
            raw_q <= '0;
         end else if (fire) begin
            raw_q.p <= wave_q;
            raw_q.n <= !wave_q;
         end
      end
   end

   assign p_raw = raw_q.p;
   assign n_raw = raw_q.n;

   generate
      if (CFG_W != 2 * DLY_W) begin : g_bad_cfg
         $error("deadtime_gen: configuration width mismatch");
      end
   endgenerate

   assign gate_p = p_raw ^ (comp_q & inv_en);
   assign gate_n = n_raw ^ (comp_q & inv_en);
endmodule

// File: rtl/deadtime_gen_chk.sv
module deadtime_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic tmr_en,
   input logic wave_in,
   input logic pwm_on,
   input logic [1:0] cmp_mode,
   input logic inv_en,
   input logic gate_p,
   input logic gate_n,
   input logic comp_q,
   input logic wave_q,
   input logic p_raw,
   input logic n_raw
);
   logic pair_sel;
   assign pair_sel = pwm_on && (cmp_mode == 2'b01);

   a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      comp_q |-> !((gate_p ^ inv_en) && (gate_n ^ inv_en)));

   a_r4_sync_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && !pair_sel) |=> (gate_p == $past(wave_in)));

   a_r4_sync_n_low: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_q |-> !gate_n);

   a_r9_fall_now: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && pair_sel && comp_q && (wave_in != wave_q))
         |=> (!(gate_p ^ inv_en) && !(gate_n ^ inv_en)));

   a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |=> ($stable(p_raw) && $stable(n_raw) && $stable(comp_q)));
endmodule

bind deadtime_gen deadtime_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tmr_en   (tmr_en),
   .wave_in  (wave_in),
   .pwm_on   (pwm_on),
   .cmp_mode (cmp_mode),
   .inv_en   (inv_en),
   .gate_p   (gate_p),
   .gate_n   (gate_n),
   .comp_q   (comp_q),
   .wave_q   (wave_q),
   .p_raw    (p_raw),
   .n_raw    (n_raw)
);

// File: tb/tb_deadtime_gen.sv
module tb_deadtime_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_en = 1'b0;
   logic       wave_in = 1'b0;
   logic       pwm_on = 1'b0;
   logic [1:0] cmp_mode = 2'b00;
   logic       inv_en = 1'b0;
   logic [1:0] div_sel = 2'b00;
   logic [7:0] dt_cfg = 8'h00;
   logic       gate_p;
   logic       gate_n;

   int    checks = 0;
   int    errors = 0;
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;
   string req = "R7";
   logic [15:0] lf = 16'hACE1;

   // behavioural reference state
   int m_ticks = 0;
   int m_cnt = 0;
   bit m_p = 0, m_n = 0, m_wq = 0, m_cq = 0, m_pend = 0;

   always #2 clk = ~clk;

   deadtime_gen dut (
      .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .wave_in(wave_in),
      .pwm_on(pwm_on), .cmp_mode(cmp_mode), .inv_en(inv_en),
      .div_sel(div_sel), .dt_cfg(dt_cfg), .gate_p(gate_p), .gate_n(gate_n)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ticks = 0; m_cnt = 0; m_p = 0; m_n = 0; m_wq = 0; m_cq = 0; m_pend = 0;
      end else if (tmr_en) begin
         bit dtt;
         bit ce;
         int period;
         period = 1 << div_sel;
         dtt = ((m_ticks % period) == period - 1);
         m_ticks = (m_ticks + 1) % 8;
         ce = pwm_on && (cmp_mode == 2'b01);
         if (!ce) begin
            m_p = wave_in; m_n = 0; m_pend = 0; m_cnt = 0;
         end else if ((wave_in != m_wq) || !m_cq) begin
            m_p = 0; m_n = 0; m_pend = 1;
            m_cnt = wave_in ? int'(dt_cfg[3:0]) : int'(dt_cfg[7:4]);
         end else if (m_pend && dtt) begin
            if (m_cnt == 0) begin
               m_p = m_wq; m_n = !m_wq; m_pend = 0;
            end else m_cnt = m_cnt - 1;
         end
         m_wq = wave_in;
         m_cq = ce;
      end
   end

   task automatic chk(input bit ok, input string r, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual p/n=%b expected p/n=%b at %0t", r, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on && !done) begin
         logic [1:0] exp;
         exp = {m_p ^ (m_cq & inv_en), m_n ^ (m_cq & inv_en)};
         chk({gate_p, gate_n} === exp, req, {gate_p, gate_n}, exp);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rnd_run(input int n, input int en_pct, input int tog_pct);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         tmr_en = (int'(lf[6:0]) % 100) < en_pct;
         if ((int'(lf[15:9]) % 100) < tog_pct) wave_in = ~wave_in;
      end
   endtask

   initial begin
      cyc(3);
      // R7: reset state
      chk({gate_p, gate_n} === 2'b00, "R7", {gate_p, gate_n}, 2'b00);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R4 / R11: synchronizer operation with gated enable
      req = "R4"; rnd_run(300, 100, 30);
      req = "R11"; rnd_run(300, 40, 30);
      // R5: PWM but other compare mode values
      pwm_on = 1'b1; cmp_mode = 2'b10; req = "R5"; rnd_run(200, 70, 30);
      cmp_mode = 2'b11; rnd_run(100, 70, 30);
      pwm_on = 1'b0; cmp_mode = 2'b01; rnd_run(100, 70, 30);
      // R6: inv_en ignored in synchronizer operation
      inv_en = 1'b1; req = "R6"; rnd_run(50, 70, 30);
      inv_en = 1'b0;

      // R12 / R8: enter complementary operation, zero delay, no division
      tmr_en = 1'b1; wave_in = 1'b0; dt_cfg = 8'h00; div_sel = 2'd0;
      pwm_on = 1'b1; req = "R12";
      cyc(1);
      chk({gate_p, gate_n} === 2'b00, "R12", {gate_p, gate_n}, 2'b00);
      cyc(4);
      wave_in = 1'b1; req = "R8";
      cyc(1);
      chk({gate_p, gate_n} === 2'b00, "R9", {gate_p, gate_n}, 2'b00);
      cyc(1);
      chk({gate_p, gate_n} === 2'b10, "R8", {gate_p, gate_n}, 2'b10);

      // R1 / R2 / R3 / R9: each prescaler setting, mixed delays
      for (int s = 0; s < 4; s++) begin
         div_sel = 2'(s); dt_cfg = 8'h3A - 8'(s * 17);
         req = "R1"; rnd_run(400, 80, 5);
         req = "R2"; dt_cfg = 8'h5E; rnd_run(300, 100, 4);
      end
      req = "R3"; div_sel = 2'd1; dt_cfg = 8'h27; rnd_run(600, 90, 8);

      // R10: retrigger before expiry keeps both outputs low
      div_sel = 2'd3; dt_cfg = 8'hFF; tmr_en = 1'b1; req = "R10";
      cyc(200);
      for (int k = 0; k < 10; k++) begin
         wave_in = ~wave_in; cyc(4);
      end
      chk({gate_p, gate_n} === 2'b00, "R10", {gate_p, gate_n}, 2'b00);

      // R6: inversion in complementary operation
      inv_en = 1'b1; div_sel = 2'd0; dt_cfg = 8'h42; req = "R6";
      cyc(30);
      wave_in = ~wave_in; cyc(1);
      chk({gate_p, gate_n} === 2'b11, "R6", {gate_p, gate_n}, 2'b11);
      rnd_run(400, 80, 6);
      inv_en = 1'b0;

      // R12: repeated mode switching
      req = "R12";
      for (int k = 0; k < 6; k++) begin
         cmp_mode = (k % 2 == 0) ? 2'b00 : 2'b01;
         rnd_run(120, 85, 6);
      end

      cyc(2);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule